// File: doc/BRIEF.md
# Execute Packet Dispatcher

This block sits between instruction fetch and issue in a wide-issue processor. It takes 256-bit fetch packets, each made of eight 32-bit instruction words, over a valid/ready handshake. It cuts each fetch packet into execute packets, which are groups of instructions that issue in the same cycle. Bit 0 of every word links that word to the word at the next higher address, so the group boundary follows the chain of these link bits and the issue width is not fixed. Each group leaves on a registered bus of eight slots, packed from slot 0, with a valid mask. The block issues at most one group per clock.

A build parameter chooses between two modes. In the confined mode every group ends at the end of its fetch packet. In the spanning mode a group whose last word still has its link bit set picks up the first words of the next fetch packet. Those leading words wait in a carry register. A merged group of more than eight words is dropped and flagged.

A multi-cycle NOP word is recognised by a configurable match pattern. Its 4-bit count sets how many issue cycles it takes. The group that contains the NOP is issued first. Empty issue cycles follow it, and nothing else issues during them.

Top module: `ep_dispatch`

## Requirements
- R1: A fetch packet is taken on a rising edge where fp_valid and fp_ready are both high. Its first execute packet is driven on ep_valid/ep_slots/ep_mask after the next rising edge. At most one execute packet issues per clock.
- R2: The link bit is bit 0 of each word, and words are scanned from word 0 (bits 31:0) upward. A word with link bit 1 shares an execute packet with the next word. A word with link bit 0 closes the current packet.
- R3: Slot k of ep_slots (bits 32k+31:32k) holds the k-th instruction of the packet in address order. ep_mask has bits 0 to size-1 set and no others.
- R4: fp_ready stays low until the last execute packet of the held fetch packet issues. It is high in that same cycle, so the next fetch packet's first execute packet issues on the very next clock.
- R5: With SPAN_EN=0 the link bit of word 7 is ignored and word 7 always closes a packet, so span_err never rises.
- R6: With SPAN_EN=1 an unclosed tail of a fetch packet is held with no issue. It is merged ahead of the leading words of the next fetch packet, up to and including that packet's first word with link bit 0.
- R7: With SPAN_EN=1, a merged packet of more than eight words gives a one-cycle span_err pulse with ep_valid low. The merged packet is discarded and scanning resumes after its last word.
- R8: A word with (word & NOP_MASK) == NOP_MATCH is a multi-cycle NOP, with its count in bits 16:13. The defaults need all other bits zero except bit 0. A count of 0 counts as 1. A packet whose largest NOP count is N issues normally and is followed by N-1 cycles with ep_valid=1 and ep_mask=0. Nothing else issues in those cycles.
- R9: Reset (rst_n low) clears the outputs to ep_valid=0, ep_mask=0, span_err=0, raises fp_ready, and discards any held carry.
- R10: In a cycle with nothing to issue, ep_valid is low and ep_mask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_valid | input | 1 | Fetch packet offered |
| fp_data | input | 256 | Eight instruction words, word 0 in bits 31:0 |
| fp_ready | output | 1 | Block can take a fetch packet this cycle |
| ep_valid | output | 1 | An issue cycle is presented (packet or NOP-empty cycle) |
| ep_slots | output | 256 | Packed instructions of the execute packet |
| ep_mask | output | 8 | Valid mask of ep_slots, contiguous from bit 0 |
| span_err | output | 1 | Merged spanning packet exceeded eight words |

## Verification
The first execute packet from a fetch packet is due after the second rising edge that counts from acceptance. Each further packet, each NOP empty cycle and each span_err pulse is due one edge after the one before it. A carry cycle in spanning mode adds one silent edge. The latency test samples at the falling edge after the accepting edge and again one edge later, and it expects the exact values at those two points. For longer streams, the monitor stamps every issue cycle with its clock count at the falling edge. The checks then compare the ordered packet contents, and they also require consecutive stamps wherever the requirements forbid gaps.

// File: rtl/epd_pkg.sv
// Shared definitions for the execute packet dispatcher.
// Assumes a 4-bit multi-cycle NOP count field.
package epd_pkg;
    localparam int NOP_CNT_W = 4;
    typedef logic [NOP_CNT_W-1:0] nop_cnt_t;

    // Effective issue cycles of a NOP: a zero count is taken as one.
    function automatic nop_cnt_t nop_cycles(input nop_cnt_t raw);
        return (raw == '0) ? nop_cnt_t'(1) : raw;
    endfunction
endpackage

// File: rtl/epd_boundary.sv
// Finds the word that closes the execute packet starting at 'start'.
// In confined mode the last word always closes; in spanning mode a set
// link bit on the last word leaves the packet open (found = 0).
// Assumes SLOTS >= 2 and start < SLOTS whenever the result is used.
module epd_boundary #(
    parameter int SLOTS   = 8,
    parameter bit SPAN_EN = 1'b0,
    parameter int IDX_W   = $clog2(SLOTS),
    parameter int CNT_W   = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] link,
    input  logic [CNT_W-1:0] start,
    output logic             found,
    output logic [IDX_W-1:0] last_idx
);
    logic [SLOTS-1:0] closes;

    generate
        if (SPAN_EN) begin : g_span
            // Every word closes only on a clear link bit.
            assign closes = ~link;
        end else begin : g_confined
            // Final word closes regardless of its link bit.
            assign closes = {1'b1, ~link[SLOTS-2:0]};
        end
    endgenerate

    // Priority scan from 'start' towards higher words.
    always_comb begin
        found    = 1'b0;
        last_idx = '0;
        for (int j = 0; j < SLOTS; j++) begin
            if (!found && (CNT_W'(j) >= start) && closes[j]) begin
                found    = 1'b1;
                last_idx = IDX_W'(j);
            end
        end
    end
endmodule

// File: rtl/epd_assemble.sv
// Builds the packed slot vector of one execute packet: held carry words
// first, then words start..last of the current fetch packet.
// Flags overflow when the merged count exceeds SLOTS.
module epd_assemble #(
    parameter int SLOTS  = 8,
    parameter int WORD_W = 32,
    parameter int IDX_W  = $clog2(SLOTS),
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS*WORD_W-1:0] words,
    input  logic [CNT_W-1:0]        start,
    input  logic                    found,
    input  logic [IDX_W-1:0]        last_idx,
    input  logic [SLOTS*WORD_W-1:0] carry,
    input  logic [CNT_W-1:0]        carry_cnt,
    output logic [SLOTS*WORD_W-1:0] slots,
    output logic [SLOTS-1:0]        mask,
    output logic [CNT_W-1:0]        gather_cnt,
    output logic                    overflow
);
    localparam int SW = CNT_W + 1;

    logic [SW-1:0] taken;
    logic [SW-1:0] total;

    // Count the words this step contributes and the merged total.
    always_comb begin
        if (found) taken = SW'(last_idx) - SW'(start) + SW'(1);
        else       taken = SW'(SLOTS) - SW'(start);
        total      = taken + SW'(carry_cnt);
        overflow   = total > SW'(SLOTS);
        gather_cnt = overflow ? '0 : total[CNT_W-1:0];
    end

    // Place carry words, then shifted fetch words, into packed slots.
    always_comb begin
        slots = '0;
        mask  = '0;
        for (int k = 0; k < SLOTS; k++) begin
            int src;
            src = k - int'(carry_cnt) + int'(start);
            if (k < int'(carry_cnt)) begin
                slots[k*WORD_W +: WORD_W] = carry[k*WORD_W +: WORD_W];
            end else if ((SW'(k) < total) && (src >= 0) && (src < SLOTS)) begin
                slots[k*WORD_W +: WORD_W] = words[src*WORD_W +: WORD_W];
            end
            mask[k] = (SW'(k) < total) && !overflow;
        end
    end
endmodule

// File: rtl/epd_nop_scan.sv
// Looks for multi-cycle NOP words among the valid slots of a packet and
// returns how many empty issue cycles must follow it (largest count - 1).
module epd_nop_scan
    import epd_pkg::*;
#(
    parameter int                SLOTS       = 8,
    parameter int                WORD_W      = 32,
    parameter logic [WORD_W-1:0] NOP_MASK    = 32'hFFFE_1FFE,
    parameter logic [WORD_W-1:0] NOP_MATCH   = 32'h0000_0000,
    parameter int                NOP_CNT_LSB = 13
) (
    input  logic [SLOTS*WORD_W-1:0] slots,
    input  logic [SLOTS-1:0]        mask,
    output nop_cnt_t                extra
);
    // Keep the largest effective count over all NOP slots.
    always_comb begin
        nop_cnt_t          best;
        logic [WORD_W-1:0] w;
        best = '0;
        for (int k = 0; k < SLOTS; k++) begin
            w = slots[k*WORD_W +: WORD_W];
            if (mask[k] && ((w & NOP_MASK) == NOP_MATCH)) begin
                if (nop_cycles(w[NOP_CNT_LSB +: NOP_CNT_W]) > best)
                    best = nop_cycles(w[NOP_CNT_LSB +: NOP_CNT_W]);
            end
        end
        extra = (best == '0) ? '0 : best - nop_cnt_t'(1);
    end
endmodule

// File: rtl/ep_dispatch.sv
// Execute packet dispatcher. Holds one fetch packet, issues one execute
// packet per clock on registered outputs, inserts NOP empty cycles, and
// (SPAN_EN=1) carries an open packet tail into the next fetch packet.
// Assumes no back-pressure from the issue side.
module ep_dispatch
    import epd_pkg::*;
#(
    parameter int                SLOTS       = 8,
    parameter int                WORD_W      = 32,
    parameter bit                SPAN_EN     = 1'b0,
    parameter logic [WORD_W-1:0] NOP_MASK    = 32'hFFFE_1FFE,
    parameter logic [WORD_W-1:0] NOP_MATCH   = 32'h0000_0000,
    parameter int                NOP_CNT_LSB = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fp_valid,
    input  logic [SLOTS*WORD_W-1:0] fp_data,
    output logic                    fp_ready,
    output logic                    ep_valid,
    output logic [SLOTS*WORD_W-1:0] ep_slots,
    output logic [SLOTS-1:0]        ep_mask,
    output logic                    span_err
);
    localparam int FP_W  = SLOTS * WORD_W;
    localparam int IDX_W = $clog2(SLOTS);
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int SW    = CNT_W + 1;

    logic [FP_W-1:0]  fp_q;
    logic             fp_full;
    logic [CNT_W-1:0] ptr;
    logic [FP_W-1:0]  carry_q;
    logic [CNT_W-1:0] carry_cnt;
    nop_cnt_t         bub_q;

    logic [SLOTS-1:0] link;
    logic             found;
    logic [IDX_W-1:0] last_idx;
    logic [FP_W-1:0]  asm_slots;
    logic [SLOTS-1:0] asm_mask;
    logic [CNT_W-1:0] gather_cnt;
    logic             ovf;
    nop_cnt_t         extra;

    logic             step;
    logic             retire;
    logic             take;
    logic             issue;
    logic             hold_carry;
    logic [SW-1:0]    next_ptr;

    generate
        for (genvar j = 0; j < SLOTS; j++) begin : g_link
            // Link bit sits in bit 0 of each word.
            assign link[j] = fp_q[j*WORD_W];
        end
    endgenerate

    epd_boundary #(
        .SLOTS(SLOTS), .SPAN_EN(SPAN_EN), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_bnd (
        .link(link), .start(ptr), .found(found), .last_idx(last_idx)
    );

    epd_assemble #(
        .SLOTS(SLOTS), .WORD_W(WORD_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_asm (
        .words(fp_q), .start(ptr), .found(found), .last_idx(last_idx),
        .carry(carry_q), .carry_cnt(carry_cnt), .slots(asm_slots),
        .mask(asm_mask), .gather_cnt(gather_cnt), .overflow(ovf)
    );

    epd_nop_scan #(
        .SLOTS(SLOTS), .WORD_W(WORD_W), .NOP_MASK(NOP_MASK),
        .NOP_MATCH(NOP_MATCH), .NOP_CNT_LSB(NOP_CNT_LSB)
    ) u_nop (
        .slots(asm_slots), .mask(asm_mask), .extra(extra)
    );

    // Step control: one scan decision per clock when no empty cycles pend.
    always_comb begin
        step       = fp_full && (bub_q == '0);
        next_ptr   = found ? (SW'(last_idx) + SW'(1)) : SW'(SLOTS);
        retire     = step && (next_ptr == SW'(SLOTS));
        fp_ready   = !fp_full || retire;
        take       = fp_valid && fp_ready;
        issue      = step && found && !ovf;
        hold_carry = step && !found && !ovf;
    end

    // Fetch packet holding register and scan pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fp_q    <= '0;
            fp_full <= 1'b0;
            ptr     <= '0;
        end else if (take) begin
            fp_q    <= fp_data;
            fp_full <= 1'b1;
            ptr     <= '0;
        end else if (retire) begin
            fp_full <= 1'b0;
        end else if (step) begin
            ptr     <= next_ptr[CNT_W-1:0];
        end
    end

    // Carry register for an open packet tail (spanning mode only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q   <= '0;
            carry_cnt <= '0;
        end else if (step) begin
            if (hold_carry) begin
                carry_q   <= asm_slots;
                carry_cnt <= gather_cnt;
            end else begin
                carry_cnt <= '0;
            end
        end
    end

    // NOP empty-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)             bub_q <= '0;
        else if (issue)         bub_q <= extra;
        else if (bub_q != '0)   bub_q <= bub_q - nop_cnt_t'(1);
    end

    // Registered issue outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ep_valid <= 1'b0;
            ep_slots <= '0;
            ep_mask  <= '0;
            span_err <= 1'b0;
        end else begin
            ep_valid <= issue || (bub_q != '0);
            ep_slots <= issue ? asm_slots : '0;
            ep_mask  <= issue ? asm_mask : '0;
            span_err <= step && ovf;
        end
    end
endmodule

// File: rtl/epd_chk.sv
// Protocol checker for ep_dispatch, attached by bind below.
module epd_chk #(
    parameter int SLOTS   = 8,
    parameter bit SPAN_EN = 1'b0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ep_valid,
    input logic [SLOTS-1:0] ep_mask,
    input logic             span_err
);
    // R3
    mask_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ep_valid |-> ((ep_mask & (ep_mask + SLOTS'(1))) == '0));

    // R10
    idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ep_valid |-> (ep_mask == '0));

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        span_err |-> !ep_valid);

    // R8
    bubble_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_valid && (ep_mask == '0)) |-> $past(ep_valid));

    generate
        if (!SPAN_EN) begin : g_confined
            // R5
            nospan_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !span_err);
        end
    endgenerate
endmodule

bind ep_dispatch epd_chk #(.SLOTS(SLOTS), .SPAN_EN(SPAN_EN)) u_chk (
    .clk(clk), .rst_n(rst_n), .ep_valid(ep_valid),
    .ep_mask(ep_mask), .span_err(span_err)
);

// File: tb/ep_dispatch_tb.sv
module ep_dispatch_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         drv_valid = 1'b0;
    logic [255:0] drv_data = '0;
    logic         sel = 1'b0;

    logic         a_ready, a_valid, a_err;
    logic [255:0] a_slots;
    logic [7:0]   a_mask;
    logic         b_ready, b_valid, b_err;
    logic [255:0] b_slots;
    logic [7:0]   b_mask;

    logic         o_ready, o_valid, o_err;
    logic [255:0] o_slots;
    logic [7:0]   o_mask;

    int total = 0, bad = 0, cyc = 0;
    bit finished = 1'b0;

    logic [255:0] cap_slots [512];
    logic [7:0]   cap_mask  [512];
    int           cap_cyc   [512];
    int           cap_n = 0;
    int           err_n = 0;

    logic [7:0]  exp_m [$];
    logic [31:0] exp_w [$];

    always #5 clk = ~clk;

    ep_dispatch #(.SPAN_EN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .fp_valid(drv_valid & ~sel),
        .fp_data(drv_data), .fp_ready(a_ready), .ep_valid(a_valid),
        .ep_slots(a_slots), .ep_mask(a_mask), .span_err(a_err)
    );

    ep_dispatch #(.SPAN_EN(1'b1)) u_dut_span (
        .clk(clk), .rst_n(rst_n), .fp_valid(drv_valid & sel),
        .fp_data(drv_data), .fp_ready(b_ready), .ep_valid(b_valid),
        .ep_slots(b_slots), .ep_mask(b_mask), .span_err(b_err)
    );

    assign o_ready = sel ? b_ready : a_ready;
    assign o_valid = sel ? b_valid : a_valid;
    assign o_err   = sel ? b_err   : a_err;
    assign o_slots = sel ? b_slots : a_slots;
    assign o_mask  = sel ? b_mask  : a_mask;

    always @(posedge clk) cyc <= cyc + 1;

    // Issue monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (o_valid && cap_n < 512) begin
                cap_slots[cap_n] = o_slots;
                cap_mask[cap_n]  = o_mask;
                cap_cyc[cap_n]   = cyc;
                cap_n            = cap_n + 1;
            end
            if (o_err) err_n = err_n + 1;
        end
    end

    // {link bits, packet count, packet sizes (nibble i = packet i)}
    localparam logic [43:0] VEC [7] = '{
        {8'h00, 4'd8, 32'h1111_1111},
        {8'h7F, 4'd1, 32'h0000_0008},
        {8'hFF, 4'd1, 32'h0000_0008},
        {8'h65, 4'd4, 32'h0000_3122},
        {8'h0F, 4'd4, 32'h0000_1115},
        {8'hF0, 4'd5, 32'h0004_1111},
        {8'hAA, 4'd5, 32'h0001_2221}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkw(input logic [7:0] id, input int idx, input logic p);
        return {8'hA5, id, 8'(idx), 7'b0, p};
    endfunction

    function automatic logic [31:0] mknop(input logic [3:0] cnt, input logic p);
        return {15'b0, cnt, 12'b0, p};
    endfunction

    function automatic logic [255:0] build(input logic [7:0] id, input logic [7:0] lk);
        logic [255:0] d;
        for (int j = 0; j < 8; j++) d[32*j +: 32] = mkw(id, j, lk[j]);
        return d;
    endfunction

    task automatic push_words(input logic [255:0] d, input int lo, input int hi);
        for (int j = lo; j <= hi; j++) exp_w.push_back(d[32*j +: 32]);
    endtask

    task automatic push_sizes(input int n, input int s);
        for (int i = 0; i < n; i++) exp_m.push_back(8'((1 << s) - 1));
    endtask

    task automatic clear_exp();
        exp_m.delete();
        exp_w.delete();
    endtask

    // Offer one fetch packet; called at a falling edge, returns at one.
    task automatic send(input logic [255:0] d);
        drv_valid = 1'b1;
        drv_data  = d;
        while (!o_ready) @(negedge clk);
        @(negedge clk);
        drv_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic check_stream(input string req, input int base, input bit adj);
        int n, pos, lim;
        n   = cap_n - base;
        pos = 0;
        chk(n == exp_m.size(), {req, " packet count"}, 64'(n), 64'(exp_m.size()));
        lim = (n < exp_m.size()) ? n : exp_m.size();
        for (int i = 0; i < lim; i++) begin
            chk(cap_mask[base+i] == exp_m[i], {req, " mask"}, 64'(cap_mask[base+i]), 64'(exp_m[i]));
            for (int k = 0; k < 8; k++) begin
                if (exp_m[i][k] && pos < exp_w.size()) begin
                    chk(cap_slots[base+i][32*k +: 32] == exp_w[pos], {req, " slot word"},
                        64'(cap_slots[base+i][32*k +: 32]), 64'(exp_w[pos]));
                    pos++;
                end
            end
            if (adj && i > 0)
                chk(cap_cyc[base+i] == cap_cyc[base+i-1] + 1, {req, " back-to-back issue"},
                    64'(cap_cyc[base+i]), 64'(cap_cyc[base+i-1] + 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int base, lows, e0;
        logic [255:0] d, d2;

        @(negedge clk);
        do_reset();
        // R9: reset state of both variants
        chk(a_valid == 0 && a_mask == 0 && a_err == 0 && a_ready == 1, "R9 reset confined",
            {a_valid, a_mask, a_err, a_ready}, 64'h1);
        chk(b_valid == 0 && b_mask == 0 && b_err == 0 && b_ready == 1, "R9 reset spanning",
            {b_valid, b_mask, b_err, b_ready}, 64'h1);

        // R2 R3 R5: table of link patterns, confined mode
        sel = 1'b0;
        for (int v = 0; v < 7; v++) begin
            clear_exp();
            d = build(8'(v), VEC[v][43:36]);
            push_words(d, 0, 7);
            for (int i = 0; i < int'(VEC[v][35:32]); i++)
                push_sizes(1, int'(VEC[v][4*i +: 4]));
            base = cap_n;
            send(d);
            idle(14);
            check_stream("R2 R3 R5 pattern", base, 1'b1);
        end

        // R1: latency from acceptance to first issue
        idle(2);
        drv_valid = 1'b1;
        drv_data  = build(8'h20, 8'h7F);
        @(posedge clk);
        @(negedge clk);
        drv_valid = 1'b0;
        chk(o_valid == 1'b0, "R1 no issue one edge after accept", 64'(o_valid), 64'h0);
        @(negedge clk);
        chk(o_valid == 1'b1 && o_mask == 8'hFF, "R1 issue two edges after accept",
            {o_valid, o_mask}, {1'b1, 8'hFF});
        idle(4);
        // R10: idle cycle
        chk(o_valid == 1'b0 && o_mask == 8'h00, "R10 idle outputs", {o_valid, o_mask}, 64'h0);

        // R4: ready held low until the last of eight packets issues
        drv_valid = 1'b1;
        drv_data  = build(8'h21, 8'h00);
        @(negedge clk);
        drv_valid = 1'b0;
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            if (!o_ready) lows++;
            @(negedge clk);
        end
        chk(lows == 7, "R4 ready low cycles", 64'(lows), 64'd7);

        // R4 R1: three fetch packets back to back, no issue gaps
        clear_exp();
        base = cap_n;
        d = build(8'h22, 8'h7F); push_words(d, 0, 7); push_sizes(1, 8); send(d);
        d = build(8'h23, 8'h00); push_words(d, 0, 7); push_sizes(8, 1); send(d);
        d = build(8'h24, 8'hFF); push_words(d, 0, 7); push_sizes(1, 8); send(d);
        idle(12);
        check_stream("R4 back-to-back", base, 1'b1);

        // R8: multi-cycle NOPs, count 3, count 0, and two in one packet (2 and 4)
        clear_exp();
        d = build(8'h30, 8'h20);
        d[32*1 +: 32] = mknop(4'd3, 1'b0);
        d[32*3 +: 32] = mknop(4'd0, 1'b0);
        d[32*5 +: 32] = mknop(4'd2, 1'b1);
        d[32*6 +: 32] = mknop(4'd4, 1'b0);
        push_words(d, 0, 7);
        exp_m = '{8'h01, 8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h03,
                  8'h00, 8'h00, 8'h00, 8'h01};
        base = cap_n;
        send(d);
        idle(20);
        check_stream("R8 NOP empty cycles", base, 1'b1);

        // R6: spanning merge of a two-word tail
        sel = 1'b1;
        idle(2);
        clear_exp();
        d  = build(8'h40, 8'hC0);
        d2 = build(8'h41, 8'h01);
        push_words(d, 0, 7); push_words(d2, 0, 7);
        push_sizes(6, 1); push_sizes(1, 4); push_sizes(6, 1);
        base = cap_n; e0 = err_n;
        send(d); send(d2);
        idle(20);
        check_stream("R6 spanning merge", base, 1'b0);
        chk(err_n == e0, "R6 no error on merge", 64'(err_n - e0), 64'd0);

        // R6 boundary: merged packet of exactly eight words
        clear_exp();
        d  = build(8'h42, 8'hF0);
        d2 = build(8'h43, 8'h07);
        push_words(d, 0, 7); push_words(d2, 0, 7);
        push_sizes(4, 1); push_sizes(1, 8); push_sizes(4, 1);
        base = cap_n; e0 = err_n;
        send(d); send(d2);
        idle(20);
        check_stream("R6 eight-word merge", base, 1'b0);
        chk(err_n == e0, "R6 no error at eight", 64'(err_n - e0), 64'd0);

        // R7: merged packet of ten words is dropped with one error pulse
        clear_exp();
        d  = build(8'h44, 8'hFC);
        d2 = build(8'h45, 8'h07);
        push_words(d, 0, 1); push_words(d2, 4, 7);
        push_sizes(6, 1);
        base = cap_n; e0 = err_n;
        send(d); send(d2);
        idle(20);
        check_stream("R7 overflow drop", base, 1'b0);
        chk(err_n - e0 == 1, "R7 error pulses", 64'(err_n - e0), 64'd1);

        // R9: reset discards a held carry
        d = build(8'h46, 8'hC0);
        send(d);
        idle(10);
        do_reset();
        clear_exp();
        d2 = build(8'h47, 8'h01);
        push_words(d2, 0, 7);
        push_sizes(1, 2); push_sizes(6, 1);
        base = cap_n;
        send(d2);
        idle(14);
        check_stream("R9 carry cleared by reset", base, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule